// File: doc/BRIEF.md
# Extended-precision floating-point compare unit

This block orders a top-of-stack operand against a source operand. Both operands arrive as 80-bit extended-precision values; any widening from single or double precision is done before the block. One cycle after an input strobe, the block reports three things:
- the three condition-code bits it writes into the floating-point status word;
- whether an invalid-operand exception was raised;
- how many register-stack pops the stack logic should perform.

The two-pop form always compares against the second stack entry. The stack logic supplies that entry on `src_val`, so this block does not treat the two-pop form as a special case.

The outputs are produced by a two-state control machine:
- `S_IDLE` means no result is being reported.
- `S_REPORT` means the pulse outputs carry the result of the previous cycle's strobe.

The machine has these transitions:
- `S_IDLE` goes to `S_REPORT` when the strobe is high.
- `S_REPORT` stays in `S_REPORT` when the strobe is high again (back-to-back compares).
- `S_REPORT` returns to `S_IDLE` when the strobe is low.
- `S_IDLE` stays in `S_IDLE` when the strobe is low.

The condition-code bits are held in registers. They keep their value until a compare writes them.

Top module: `fpx_compare`

## Requirements
- R1: When the top operand is greater than the source, the written code is C3=0, C2=0, C0=0.
- R2: When the top operand is less than the source, the written code is C3=0, C2=0, C0=1.
- R3: When the operands are equal, the written code is C3=1, C2=0, C0=0. A zero of either sign equals a zero of either sign.
- R4: `inv_exc` pulses when either operand is invalid for this compare. An operand is invalid in any of these cases:
  - the exponent field (bits 78:64) is all ones and the significand (bits 63:0) is not exactly 0x8000_0000_0000_0000 (quiet or signalling NaN, or a maximum-exponent value with bit 63 clear);
  - the exponent is neither zero nor all ones and integer bit 63 is clear.
- R5: When an invalid operand is seen with `ie_mask`=1, the unordered code C3=1, C2=1, C0=1 is written (`cc_we`=1).
- R6: When an invalid operand is seen with `ie_mask`=0, `cc_we` stays 0, the held condition bits keep their previous values, and `pop_cnt` is 0.
- R7: On a compare that is not trapped, `pop_cnt` follows `cmd`: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives 2, and the reserved 2'b11 gives 0.
- R8: `out_valid`, `cc_we`, `inv_exc` and `pop_cnt` reflect a strobe exactly one cycle after it. They are 0 / 0 in any cycle that does not follow a strobe. Back-to-back strobes give back-to-back results.
- R9: Denormals (zero exponent field) and infinities are ordered by magnitude with the usual sign rules. Two infinities of the same sign compare equal.
- R10: While reset is active, and after it until the first strobe, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare strobe |
| cmd | input | 2 | Pop selection: 00 none, 01 one, 10 two, 11 reserved (none) |
| ie_mask | input | 1 | 1 = invalid-operand exception masked |
| top_val | input | 80 | Top-of-stack operand, extended precision |
| src_val | input | 80 | Source operand, extended precision |
| out_valid | output | 1 | Result cycle indicator |
| cc_we | output | 1 | Condition-code write enable |
| cc_c3 | output | 1 | Held condition bit C3 |
| cc_c2 | output | 1 | Held condition bit C2 |
| cc_c0 | output | 1 | Held condition bit C0 |
| inv_exc | output | 1 | Invalid-operand exception pulse |
| pop_cnt | output | 2 | Number of stack pops to perform |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle strobe-to-result relation;
- quiet outputs between results;
- the held flags staying stable whenever no write occurs;
- the unordered code appearing only together with the exception;
- a trapped compare never requesting a pop;
- the signed-zero equality as seen by the classifiers.

The bench's scenarios are needed for the rest:
- the ordering itself across normals, denormals, infinities and zeros of both signs;
- the classification of each invalid encoding;
- the exact pop count for each command.

A behavioural reference model predicts the port values for every cycle, and a random mix of operands, masks and strobe gaps is compared against it.

// File: rtl/fpx_cmp_pkg.sv
package fpx_cmp_pkg;

    typedef enum logic [1:0] {
        CMD_KEEP = 2'b00,
        CMD_POP1 = 2'b01,
        CMD_POP2 = 2'b10,
        CMD_RSVD = 2'b11
    } cmp_cmd_e;

    typedef enum logic [1:0] {
        ORD_GT = 2'b00,
        ORD_LT = 2'b01,
        ORD_EQ = 2'b10
    } cmp_ord_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } cmp_state_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c0;
    } cc_bits_t;

    // Condition code for an ordering, or the unordered code when invalid.
    function automatic cc_bits_t cc_code(input cmp_ord_e ord, input logic bad);
        cc_bits_t r;
        r.c3 = bad | (ord == ORD_EQ);
        r.c2 = bad;
        r.c0 = bad | (ord == ORD_LT);
        return r;
    endfunction

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify #(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64
) (
    input  logic [EXP_W+MAN_W:0]   val,
    output logic                   sign,
    output logic                   is_zero,
    output logic                   is_bad,
    output logic [EXP_W+MAN_W-1:0] key
);
    localparam int TOT_W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             int_bit;
    logic             frac_nz;
    logic             exp_zero;
    logic             exp_max;
    logic             is_nan;
    logic             is_pseudo;
    logic             is_unnorm;

    assign sign     = val[TOT_W-1];
    assign exp_f    = val[TOT_W-2 -: EXP_W];
    assign man_f    = val[MAN_W-1:0];
    assign int_bit  = man_f[MAN_W-1];
    assign frac_nz  = |man_f[MAN_W-2:0];
    assign exp_zero = (exp_f == '0);
    assign exp_max  = &exp_f;

    // NaN of either kind, maximum exponent without integer bit, or unnormal.
    assign is_nan    = exp_max & int_bit & frac_nz;
    assign is_pseudo = exp_max & ~int_bit;
    assign is_unnorm = ~exp_zero & ~exp_max & ~int_bit;
    assign is_bad    = is_nan | is_pseudo | is_unnorm;

    assign is_zero   = exp_zero & (man_f == '0);

    // Denormals share the scale of exponent one, so the key is monotonic in magnitude.
    assign key = {(exp_zero ? EXP_W'(1) : exp_f), man_f};

endmodule

// File: rtl/fpx_order.sv
module fpx_order
    import fpx_cmp_pkg::*;
#(
    parameter int KEY_W = 79
) (
    input  logic             a_sign,
    input  logic             a_zero,
    input  logic [KEY_W-1:0] a_key,
    input  logic             b_sign,
    input  logic             b_zero,
    input  logic [KEY_W-1:0] b_key,
    output cmp_ord_e         ord
);
    logic mag_gt;
    logic mag_eq;

    assign mag_gt = (a_key > b_key);
    assign mag_eq = (a_key == b_key);

    always_comb begin
        if (a_zero && b_zero) begin
            ord = ORD_EQ;
        end else if (a_sign != b_sign) begin
            ord = a_sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            ord = ORD_EQ;
        end else if (mag_gt ^ a_sign) begin
            ord = ORD_GT;
        end else begin
            ord = ORD_LT;
        end
    end

endmodule

// File: rtl/fpx_cmp_ctrl.sv
module fpx_cmp_ctrl
    import fpx_cmp_pkg::*;
#(
    parameter int POP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       cmd,
    input  logic             ie_mask,
    input  logic             any_bad,
    input  cmp_ord_e         ord,
    output logic             out_valid,
    output logic             cc_we,
    output logic             cc_c3,
    output logic             cc_c2,
    output logic             cc_c0,
    output logic             inv_exc,
    output logic [POP_W-1:0] pop_cnt
);
    cmp_state_e       state_q, state_d;
    logic             trap;
    logic [POP_W-1:0] pop_req;
    cc_bits_t         code;
    cc_bits_t         flags_q;
    logic             we_q;
    logic             exc_q;
    logic [POP_W-1:0] pop_q;

    assign trap = any_bad & ~ie_mask;
    assign code = cc_code(ord, any_bad);

    always_comb begin
        unique case (cmp_cmd_e'(cmd))
            CMD_KEEP: pop_req = POP_W'(0);
            CMD_POP1: pop_req = POP_W'(1);
            CMD_POP2: pop_req = POP_W'(2);
            CMD_RSVD: pop_req = POP_W'(0);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:   state_d = in_valid ? S_REPORT : S_IDLE;
            S_REPORT: state_d = in_valid ? S_REPORT : S_IDLE;
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            exc_q   <= 1'b0;
            pop_q   <= '0;
            flags_q <= '0;
        end else if (in_valid) begin
            we_q  <= ~trap;
            exc_q <= any_bad;
            pop_q <= trap ? '0 : pop_req;
            if (!trap) begin
                flags_q <= code;
            end
        end else begin
            we_q  <= 1'b0;
            exc_q <= 1'b0;
            pop_q <= '0;
        end
    end

    assign out_valid = (state_q == S_REPORT);
    assign cc_we     = we_q;
    assign inv_exc   = exc_q;
    assign pop_cnt   = pop_q;
    assign cc_c3     = flags_q.c3;
    assign cc_c2     = flags_q.c2;
    assign cc_c0     = flags_q.c0;

    AST_REPORT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !cc_we && !inv_exc && pop_cnt == '0)); // R8
    AST_WE_ONLY_IN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> out_valid); // R8
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |-> $stable({cc_c3, cc_c2, cc_c0})); // R6
    AST_UNORDERED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_we && cc_c2) |-> (cc_c3 && cc_c0 && inv_exc)); // R5
    AST_TRAP_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_exc && !cc_we) |-> (pop_cnt == '0)); // R6
    AST_POP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt != POP_W'(3)); // R7
    AST_EXC_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        inv_exc |-> $past(any_bad && in_valid)); // R4

endmodule

// File: rtl/fpx_compare.sv
module fpx_compare
    import fpx_cmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    parameter int POP_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             cmd,
    input  logic                   ie_mask,
    input  logic [EXP_W+MAN_W:0]   top_val,
    input  logic [EXP_W+MAN_W:0]   src_val,
    output logic                   out_valid,
    output logic                   cc_we,
    output logic                   cc_c3,
    output logic                   cc_c2,
    output logic                   cc_c0,
    output logic                   inv_exc,
    output logic [POP_W-1:0]       pop_cnt
);
    localparam int OP_W  = EXP_W + MAN_W + 1;
    localparam int KEY_W = EXP_W + MAN_W;
    localparam int N_OP  = 2;

    logic [OP_W-1:0]  opnd   [N_OP];
    logic             o_sign [N_OP];
    logic             o_zero [N_OP];
    logic             o_bad  [N_OP];
    logic [KEY_W-1:0] o_key  [N_OP];
    cmp_ord_e         ord;
    logic             any_bad;

    assign opnd[0] = top_val;
    assign opnd[1] = src_val;

    for (genvar gi = 0; gi < N_OP; gi++) begin : g_cls
        fpx_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .val     (opnd[gi]),
            .sign    (o_sign[gi]),
            .is_zero (o_zero[gi]),
            .is_bad  (o_bad[gi]),
            .key     (o_key[gi])
        );
    end

    assign any_bad = o_bad[0] | o_bad[1];

    fpx_order #(
        .KEY_W (KEY_W)
    ) u_order (
        .a_sign (o_sign[0]),
        .a_zero (o_zero[0]),
        .a_key  (o_key[0]),
        .b_sign (o_sign[1]),
        .b_zero (o_zero[1]),
        .b_key  (o_key[1]),
        .ord    (ord)
    );

    fpx_cmp_ctrl #(
        .POP_W (POP_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cmd       (cmd),
        .ie_mask   (ie_mask),
        .any_bad   (any_bad),
        .ord       (ord),
        .out_valid (out_valid),
        .cc_we     (cc_we),
        .cc_c3     (cc_c3),
        .cc_c2     (cc_c2),
        .cc_c0     (cc_c0),
        .inv_exc   (inv_exc),
        .pop_cnt   (pop_cnt)
    );

    AST_SIGNED_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && o_zero[0] && o_zero[1]) |=> (cc_we && cc_c3 && !cc_c2 && !cc_c0)); // R3
    AST_BAD_RAISES_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (o_bad[0] || o_bad[1])) |=> inv_exc); // R4

endmodule

// File: tb/fpx_compare_bench.sv
module fpx_compare_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic        ie_mask = 1'b0;
    logic [79:0] top_val = '0;
    logic [79:0] src_val = '0;
    logic        out_valid, cc_we, cc_c3, cc_c2, cc_c0, inv_exc;
    logic [1:0]  pop_cnt;

    int checks = 0;
    int errors = 0;

    // Predicted port values for the cycle after the current one.
    logic       p_valid = 0, p_we = 0, p_exc = 0;
    logic [1:0] p_pop = 0;
    logic [2:0] m_flags = 0;
    string      pend_tag = "R10";

    localparam logic [79:0] V_ONE   = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_TWO   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_MONE  = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_MTWO  = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_PZ    = 80'h0;
    localparam logic [79:0] V_NZ    = {1'b1, 79'h0};
    localparam logic [79:0] V_DEN1  = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
    localparam logic [79:0] V_DEN2  = {1'b0, 15'h0000, 64'h0000_0000_0000_0002};
    localparam logic [79:0] V_MINN  = {1'b0, 15'h0001, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_INF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_MINF  = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] V_QNAN  = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] V_SNAN  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001};
    localparam logic [79:0] V_UNRM  = {1'b0, 15'h3FFF, 64'h4000_0000_0000_0000};
    localparam logic [79:0] V_PINF  = {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000};

    fpx_compare u_fpx_compare (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd(cmd), .ie_mask(ie_mask),
        .top_val(top_val), .src_val(src_val), .out_valid(out_valid), .cc_we(cc_we),
        .cc_c3(cc_c3), .cc_c2(cc_c2), .cc_c0(cc_c0), .inv_exc(inv_exc), .pop_cnt(pop_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ref_bad(logic [79:0] x);
        logic [14:0] e;
        logic [63:0] m;
        e = x[78:64];
        m = x[63:0];
        if (e == 15'h7FFF) return (m != 64'h8000_0000_0000_0000);
        if (e != 15'h0 && !m[63]) return 1'b1;
        return 1'b0;
    endfunction

    // Magnitude ordering: 1 greater, -1 less, 0 equal.
    function automatic int ref_mag(logic [79:0] a, logic [79:0] b);
        logic [14:0] ea, eb;
        logic [63:0] ma, mb;
        ea = a[78:64]; eb = b[78:64]; ma = a[63:0]; mb = b[63:0];
        if (ea == eb || (ea == 0 && eb == 1) || (ea == 1 && eb == 0)) begin
            if (ma > mb) return 1;
            if (ma < mb) return -1;
            return 0;
        end
        return (ea > eb) ? 1 : -1;
    endfunction

    // 0 greater, 1 less, 2 equal, 3 invalid.
    function automatic int ref_order(logic [79:0] a, logic [79:0] b);
        int mg;
        if (ref_bad(a) || ref_bad(b)) return 3;
        if (a[78:0] == 0 && b[78:0] == 0) return 2;
        if (a[79] != b[79]) return a[79] ? 1 : 0;
        mg = ref_mag(a, b);
        if (mg == 0) return 2;
        if (a[79]) mg = -mg;
        return (mg > 0) ? 0 : 1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        chk(pend_tag, "out_valid", out_valid, p_valid);
        chk(pend_tag, "cc_we", cc_we, p_we);
        chk(pend_tag, "inv_exc", inv_exc, p_exc);
        chk(pend_tag, "pop_cnt", pop_cnt, p_pop);
        chk(pend_tag, "flags", {cc_c3, cc_c2, cc_c0}, m_flags);
    endtask

    task automatic step(input string tag, input bit v, input logic [1:0] c,
                        input bit msk, input logic [79:0] a, input logic [79:0] b);
        int  o;
        bit  trap;
        @(negedge clk);
        compare_now();
        in_valid = v; cmd = c; ie_mask = msk; top_val = a; src_val = b;
        pend_tag = tag;
        if (v) begin
            o = ref_order(a, b);
            trap = (o == 3) && !msk;
            p_valid = 1'b1;
            p_exc = (o == 3);
            p_we = !trap;
            p_pop = trap ? 2'd0 : (c == 2'b01 ? 2'd1 : (c == 2'b10 ? 2'd2 : 2'd0));
            if (!trap) begin
                case (o)
                    0: m_flags = 3'b000;
                    1: m_flags = 3'b001;
                    2: m_flags = 3'b100;
                    default: m_flags = 3'b111;
                endcase
            end
        end else begin
            p_valid = 0; p_we = 0; p_exc = 0; p_pop = 0;
        end
    endtask

    function automatic logic [79:0] pick(int k);
        case (k % 15)
            0: return V_ONE;   1: return V_TWO;   2: return V_MONE;
            3: return V_MTWO;  4: return V_PZ;    5: return V_NZ;
            6: return V_DEN1;  7: return V_DEN2;  8: return V_MINN;
            9: return V_INF;   10: return V_MINF; 11: return V_QNAN;
            12: return V_SNAN; 13: return V_UNRM; default: return V_PINF;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_now();               // R10 during reset
        rst_n = 1'b1;
        step("R10", 0, 2'b00, 1, V_ONE, V_TWO);
        step("R10", 0, 2'b01, 0, V_QNAN, V_ONE);   // no strobe: quiet
        // R1 greater
        step("R1", 1, 2'b00, 1, V_TWO, V_ONE);
        step("R1", 1, 2'b00, 1, V_MONE, V_MTWO);
        // R2 less
        step("R2", 1, 2'b00, 1, V_ONE, V_TWO);
        step("R2", 1, 2'b00, 1, V_MTWO, V_ONE);
        // R3 equal and signed zeros
        step("R3", 1, 2'b00, 1, V_ONE, V_ONE);
        step("R3", 1, 2'b00, 1, V_PZ, V_NZ);
        step("R3", 1, 2'b00, 1, V_NZ, V_PZ);
        // R9 denormals and infinities
        step("R9", 1, 2'b00, 1, V_DEN2, V_DEN1);
        step("R9", 1, 2'b00, 1, V_DEN1, V_MINN);
        step("R9", 1, 2'b00, 1, V_INF, V_INF);
        step("R9", 1, 2'b00, 1, V_MINF, V_MINF);
        step("R9", 1, 2'b00, 1, V_INF, V_TWO);
        step("R9", 1, 2'b00, 1, V_MINF, V_DEN1);
        step("R9", 1, 2'b00, 1, V_PZ, V_DEN1);
        // R4 / R5 masked invalid encodings
        step("R5", 1, 2'b00, 1, V_QNAN, V_ONE);
        step("R4", 1, 2'b00, 0, V_ONE, V_ONE);
        step("R4", 1, 2'b00, 1, V_ONE, V_SNAN);
        step("R4", 1, 2'b00, 1, V_UNRM, V_ONE);
        step("R4", 1, 2'b00, 1, V_ONE, V_PINF);
        // R6 unmasked: flags held, no pop
        step("R6", 1, 2'b00, 0, V_TWO, V_ONE);
        step("R6", 1, 2'b10, 0, V_QNAN, V_ONE);
        step("R6", 0, 2'b00, 0, V_ONE, V_ONE);
        step("R6", 1, 2'b01, 0, V_ONE, V_UNRM);
        // R7 pop counts
        step("R7", 1, 2'b01, 1, V_ONE, V_TWO);
        step("R7", 1, 2'b10, 1, V_ONE, V_TWO);
        step("R7", 1, 2'b11, 1, V_ONE, V_TWO);
        step("R7", 1, 2'b10, 1, V_SNAN, V_TWO);
        // R8 gaps and back-to-back
        step("R8", 0, 2'b10, 1, V_ONE, V_TWO);
        step("R8", 1, 2'b01, 1, V_TWO, V_ONE);
        step("R8", 0, 2'b01, 1, V_TWO, V_ONE);
        step("R8", 0, 2'b01, 1, V_TWO, V_ONE);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [79:0] a, b;
            a = pick($urandom % 15);
            b = pick($urandom % 15);
            if ($urandom % 4 == 0) a[79] = ~a[79];
            step("R8", ($urandom % 4) != 0, 2'($urandom), 1'($urandom), a, b);
        end
        step("R8", 0, 2'b00, 0, V_ONE, V_ONE);
        @(negedge clk);
        compare_now();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule